// File: doc/BRIEF.md
# Stall-Insertion Power Controller

This block sits next to a pipelined processor core that always runs at its full rated clock. Instead of lowering the clock frequency to save power, it slows the core down by holding fetch for a programmable number of empty cycles after every real instruction. The core sees those cycles as injected no-operation bubbles. While a bubble is in flight, the block raises registered power-control outputs for the datapath units that have nothing to do: an ALU power-down request, a register-file clock-gate enable, a data-memory sleep request and a pipeline-register clock-gate enable.

A single enable selects power-saving operation. A 3-bit factor gives the number of bubble cycles per instruction. The core presents an instruction on `issue_i`, and that instruction is accepted in any cycle where `stall_o` is low. The block latches the enable and the factor at that acceptance, so a setting that changes during a burst never shortens or lengthens it. `wake_o` marks the last bubble cycle of each burst, which gives the slept units one cycle of warning before the next instruction issues. Two free-running counters report accepted instructions and bubble cycles.

Top module: `stall_pwr_ctrl`

## Requirements
- R1: While `rst_ni` is low and right after its release, `stall_o`, `wake_o`, all four power outputs and both counters are zero.
- R2: An accepted issue (`issue_i`=1 while `stall_o`=0) with `slow_en_i`=1 and `slow_factor_i`=m>0 makes `stall_o` high for exactly m consecutive cycles, starting the cycle after acceptance. `stall_o` is low in the cycle after the burst.
- R3: If `slow_en_i`=0 or `slow_factor_i`=0 at acceptance, no stall follows and all power outputs stay low. An instruction held on `issue_i` is then accepted every cycle.
- R4: `alu_pd_o`, `rf_gate_o`, `dmem_sleep_o` and `preg_gate_o` are all 1 in every cycle where `stall_o` is 1, and all 0 in every other cycle.
- R5: `wake_o` is 1 only in the last stall cycle of a burst, so it is followed by a cycle with `stall_o` low.
- R6: `slow_en_i` and `slow_factor_i` are sampled only at an accepted issue. Changing either during a burst does not change that burst's length.
- R7: `issue_i` high during a stall cycle is not accepted. It is not counted and does not restart or extend the burst.
- R8: `instr_cnt_o` increments once per accepted issue and `nop_cnt_o` once per stall cycle. After bursts that all use factor m, nop_cnt = m × instr_cnt.
- R9: The largest factor, 7, gives a burst of exactly 7 stall cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rated processor clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| slow_en_i | input | 1 | Power-saving mode enable |
| slow_factor_i | input | 3 | Bubble cycles per instruction (m) |
| issue_i | input | 1 | Core presents a real instruction for issue |
| stall_o | output | 1 | Fetch hold / bubble inject strobe |
| wake_o | output | 1 | Last bubble cycle; supplies restore next |
| alu_pd_o | output | 1 | ALU power-down request |
| rf_gate_o | output | 1 | Register-file clock-gate enable |
| dmem_sleep_o | output | 1 | Data-memory sleep request |
| preg_gate_o | output | 1 | Pipeline-register clock-gate enable |
| instr_cnt_o | output | 16 | Accepted instruction count |
| nop_cnt_o | output | 16 | Stall cycle count |

## Verification
The bench checks burst length at the edges of the factor range: 1, where the wake cycle is also the first stall cycle, and 7, where a width or off-by-one error would drop or add a bubble. It changes the factor and the enable in the middle of a burst; a design that re-reads them every cycle would cut the burst short or stretch it. It keeps issue held high through the bursts; a design that accepts during a stall would count extra instructions and restart the burst, which breaks the nop = m × instr ratio. It also runs the bypass cases with the enable off and with m=0, where a leak in the power outputs or a one-cycle stall would show up.

// File: rtl/spc_pkg.sv
package spc_pkg;
  localparam int unsigned FACT_W  = 3;
  localparam int unsigned N_UNITS = 4;
  localparam int unsigned CNT_W   = 16;

  typedef enum logic [1:0] {
    UNIT_ALU  = 2'd0,
    UNIT_RF   = 2'd1,
    UNIT_DMEM = 2'd2,
    UNIT_PREG = 2'd3
  } unit_e;
endpackage

// File: rtl/spc_burst_seq.sv
module spc_burst_seq #(
  parameter int unsigned FACT_W = spc_pkg::FACT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_i,
  input  logic              en_i,
  input  logic [FACT_W-1:0] fact_i,
  output logic              stall_o,
  output logic              accept_o,
  output logic              burst_nxt_o,
  output logic              last_nxt_o
);
  logic [FACT_W-1:0] left_q, left_d;
  logic              stall_q;

  assign accept_o = issue_i & ~stall_q;

  always_comb begin
    left_d = left_q;
    if (accept_o) left_d = en_i ? fact_i : '0;
    else if (left_q != '0) left_d = left_q - 1'b1;
  end

  assign burst_nxt_o = (left_d != '0);
  assign last_nxt_o  = (left_d == FACT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q  <= '0;
      stall_q <= 1'b0;
    end else begin
      left_q  <= left_d;
      stall_q <= burst_nxt_o;
    end
  end

  assign stall_o = stall_q;

  // R2
  start_burst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o && en_i && fact_i != '0) |=> stall_o);
  // R3
  bypass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o && (!en_i || fact_i == '0)) |=> !stall_o);
  // R7
  no_accept_in_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> !accept_o);
endmodule

// File: rtl/spc_pwr_regs.sv
module spc_pwr_regs #(
  parameter int unsigned N_UNITS = spc_pkg::N_UNITS
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               burst_nxt_i,
  input  logic               last_nxt_i,
  output logic [N_UNITS-1:0] sleep_o,
  output logic               wake_o
);
  // one flop per unit so each control leaves its own register, glitch-free
  for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sleep_o[u] <= 1'b0;
      else         sleep_o[u] <= burst_nxt_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wake_o <= 1'b0;
    else         wake_o <= last_nxt_i;
  end

  // R5
  wake_needs_sleep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> sleep_o[0]);
endmodule

// File: rtl/spc_perf_cnt.sv
module spc_perf_cnt #(
  parameter int unsigned N_CNT = 2,
  parameter int unsigned CNT_W = spc_pkg::CNT_W
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [N_CNT-1:0]            inc_i,
  output logic [N_CNT-1:0][CNT_W-1:0] cnt_o
);
  for (genvar c = 0; c < N_CNT; c++) begin : g_cnt
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       cnt_o[c] <= '0;
      else if (inc_i[c]) cnt_o[c] <= cnt_o[c] + 1'b1;
    end

    // R8
    cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !inc_i[c] |=> $stable(cnt_o[c]));
  end
endmodule

// File: rtl/stall_pwr_ctrl.sv
module stall_pwr_ctrl
  import spc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slow_en_i,
  input  logic [FACT_W-1:0] slow_factor_i,
  input  logic              issue_i,
  output logic              stall_o,
  output logic              wake_o,
  output logic              alu_pd_o,
  output logic              rf_gate_o,
  output logic              dmem_sleep_o,
  output logic              preg_gate_o,
  output logic [CNT_W-1:0]  instr_cnt_o,
  output logic [CNT_W-1:0]  nop_cnt_o
);
  logic               accept, burst_nxt, last_nxt;
  logic [N_UNITS-1:0] sleep;
  logic [1:0][CNT_W-1:0] cnts;

  spc_burst_seq #(.FACT_W(FACT_W)) i_seq (
    .clk_i, .rst_ni,
    .issue_i, .en_i(slow_en_i), .fact_i(slow_factor_i),
    .stall_o, .accept_o(accept),
    .burst_nxt_o(burst_nxt), .last_nxt_o(last_nxt)
  );

  spc_pwr_regs #(.N_UNITS(N_UNITS)) i_pwr (
    .clk_i, .rst_ni,
    .burst_nxt_i(burst_nxt), .last_nxt_i(last_nxt),
    .sleep_o(sleep), .wake_o
  );

  spc_perf_cnt #(.N_CNT(2), .CNT_W(CNT_W)) i_perf (
    .clk_i, .rst_ni,
    .inc_i({stall_o, accept}),
    .cnt_o(cnts)
  );

  assign alu_pd_o     = sleep[UNIT_ALU];
  assign rf_gate_o    = sleep[UNIT_RF];
  assign dmem_sleep_o = sleep[UNIT_DMEM];
  assign preg_gate_o  = sleep[UNIT_PREG];
  assign instr_cnt_o  = cnts[0];
  assign nop_cnt_o    = cnts[1];

  // R4
  sleep_in_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> (alu_pd_o && rf_gate_o && dmem_sleep_o && preg_gate_o));
  // R4
  awake_outside_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stall_o |-> !(alu_pd_o || rf_gate_o || dmem_sleep_o || preg_gate_o));
  // R5
  wake_ends_burst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> !stall_o);
  // R6
  burst_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o && !wake_o) |=> stall_o);
  // R7
  instr_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> $stable(instr_cnt_o));
endmodule

// File: tb/test_stall_pwr_ctrl.sv
module test_stall_pwr_ctrl;
  logic clk = 0, rst_n = 0;
  logic en = 0, issue = 0;
  logic [2:0] fact = 0;
  logic stall, wake, alu, rf, dm, pr;
  logic [15:0] icnt, ncnt;
  int n_chk = 0, n_bad = 0;
  int exp_i = 0, exp_n = 0;

  always #5 clk = ~clk;

  stall_pwr_ctrl i_stall_pwr_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .slow_en_i(en), .slow_factor_i(fact),
    .issue_i(issue), .stall_o(stall), .wake_o(wake), .alu_pd_o(alu),
    .rf_gate_o(rf), .dmem_sleep_o(dm), .preg_gate_o(pr),
    .instr_cnt_o(icnt), .nop_cnt_o(ncnt)
  );

  wire [3:0] pwr = {pr, dm, rf, alu};

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_cnts(input string req);
    chk(req, "instr_cnt", int'(icnt), exp_i);
    chk(req, "nop_cnt", int'(ncnt), exp_n);
  endtask

  // R1
  task automatic t_reset();
    rst_n = 0;
    repeat (2) @(negedge clk);
    chk("R1", "stall in reset", stall, 0);
    chk("R1", "pwr in reset", pwr, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "stall after reset", stall, 0);
    chk("R1", "wake after reset", wake, 0);
    chk("R1", "pwr after reset", pwr, 0);
    chk_cnts("R1");
  endtask

  // one issue with factor m, then watch the whole burst (R2, R4, R5, R9)
  task automatic t_burst(input int m, input string req);
    @(negedge clk);
    en = 1; fact = 3'(m); issue = 1;
    chk(req, "stall before issue", stall, 0);
    @(negedge clk);
    issue = 0; exp_i++;
    for (int k = 1; k <= m; k++) begin
      chk(req, "stall in burst", stall, 1);
      chk("R4", "pwr in burst", pwr, 15);
      chk("R5", "wake", wake, (k == m) ? 1 : 0);
      exp_n++;
      @(negedge clk);
    end
    chk(req, "stall after burst", stall, 0);
    chk("R4", "pwr after burst", pwr, 0);
    chk("R5", "wake after burst", wake, 0);
    chk_cnts("R8");
  endtask

  // R3: disabled, or factor 0 -> every cycle accepted, no stall
  task automatic t_bypass(input bit e, input int m);
    @(negedge clk);
    en = e; fact = 3'(m); issue = 1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      exp_i++;
      chk("R3", "stall in bypass", stall, 0);
      chk("R3", "pwr in bypass", pwr, 0);
    end
    issue = 0;
    chk_cnts("R3");
  endtask

  // R6: factor/enable changes mid-burst ignored
  task automatic t_change_mid();
    @(negedge clk);
    en = 1; fact = 3'd3; issue = 1;
    @(negedge clk);
    issue = 0; exp_i++;
    chk("R6", "stall cycle 1", stall, 1);
    fact = 3'd7; en = 0; exp_n++;
    @(negedge clk);
    chk("R6", "stall cycle 2", stall, 1);
    fact = 3'd1; exp_n++;
    @(negedge clk);
    chk("R6", "stall cycle 3", stall, 1);
    chk("R6", "wake cycle 3", wake, 1);
    exp_n++;
    @(negedge clk);
    chk("R6", "stall after 3", stall, 0);
    chk_cnts("R6");
  endtask

  // R7/R8: issue held high through bursts
  task automatic t_held_issue(input int m, input int n);
    int base_i, base_n;
    @(negedge clk);
    base_i = int'(icnt); base_n = int'(ncnt);
    en = 1; fact = 3'(m); issue = 1;
    for (int k = 0; k < n * (m + 1); k++) begin
      @(negedge clk);
      if (k % (m + 1) == 0) chk("R7", "stall after accept", stall, (m > 0) ? 1 : 0);
    end
    issue = 0;
    chk("R7", "stall at period end", stall, 0);
    chk("R7", "instr accepted", int'(icnt) - base_i, n);
    chk("R8", "nop ratio", int'(ncnt) - base_n, m * (int'(icnt) - base_i));
    exp_i += n; exp_n += m * n;
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_burst(1, "R2");
        t_burst(3, "R2");
        t_burst(7, "R9");
        t_bypass(1'b0, 5);
        t_bypass(1'b1, 0);
        t_change_mid();
        t_held_issue(2, 5);
        t_held_issue(4, 3);
        t_burst(2, "R2");
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule